// File: doc/BRIEF.md
# Paged read-only memory window

This block makes a 1024-byte constant memory visible to a host through a byte-wide register bus whose 8-bit address space is split in two halves. The lower half holds control registers. The upper half, addresses 0x80 to 0xFF, is a 128-byte window onto one page of the memory. A page register, placed at address 0x0B, chooses which of eight pages is shown in the window. To reach the whole memory, the host reads a page, rewrites the page register, and then reads the next page.

The bus has an address, a read strobe, a sequential-read qualifier, a write strobe and write data. Read data comes back on a registered output together with a valid flag. Both appear two clock edges after the read strobe. For sequential reads, the block keeps an internal offset pointer. Each sequential read takes the byte at that pointer and then moves the pointer on by one. When the pointer passes the end of the window, it wraps to the start of the same page, so a burst never moves into the next page by itself. The memory contents come from a constant function evaluated at elaboration time, so the array can map onto block RAM with an initial image.

Top module: `nvm_page_window`

## Requirements
- R1: After a synchronous reset, `bus_rvalid` is 0 and the page register at 0x0B reads back as 0x00. This selects page 0 with the addressing-mode bit (bit 3) cleared.
- R2: A read at an address A from 0x80 to 0xFF returns the memory byte at index page*128 + (A & 0x7F). The byte at index i has the value (i*5 + (i>>7)*59 + 17) mod 256.
- R3: Bits [2:0] of the page register at 0x0B select the page shown in the window.
- R4: A write to 0x0B stores all 8 data bits, and a later read of 0x0B returns the stored byte.
- R5: Bit 3 of the page register (1 means two-byte addressing) is stored and read back, but it has no effect on window reads. Only one-byte addressing is implemented.
- R6: A read with `bus_seq`=1 ignores `bus_addr` and reads the window at the internal offset pointer. It then increments the pointer. A non-sequential window read at A sets the pointer to (A & 0x7F)+1. The pointer wraps from offset 0x7F (address 0xFF) back to offset 0 (address 0x80) on the same page.
- R7: A read issued on the cycle after a page-register write already uses the new page. No wait cycles are needed.
- R8: Writes to window addresses 0x80 to 0xFF change neither the memory contents nor the page register.
- R9: `bus_rvalid` rises exactly two clock edges after a cycle with `bus_rd`=1 and at no other time. `bus_rdata` holds its value while no read completes.
- R10: Reads of any address below 0x80 other than 0x0B return 0x00. Writes to those addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_seq | input | 1 | Sequential read: use the internal offset pointer |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, two edges after `bus_rd` |

## Verification
The assertions check on every cycle that the page register changes only through a write to 0x0B and always takes the written byte. They also check that the valid flag follows each read strobe by exactly two edges, and that read data stays still between completed reads. Only the bench's scenarios can show that the returned bytes are correct for a given page and offset, that the sequential pointer wraps inside a page, that a page change takes effect on the very next read, and that window writes leave the contents untouched.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  // Constant memory image: byte i = (i*5 + (i>>7)*59 + 17) mod 256
  function automatic logic [DATA_W-1:0] rom_init(input int idx);
    int v;
    v = idx * 5 + (idx >>> 7) * 59 + 17;
    return v[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/nvw_mode_reg.sv
module nvw_mode_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h0B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode
);
  logic hit;
  assign hit = wr_en && (addr == MODE_ADDR);

  always_ff @(posedge clk) begin
    if (rst)      mode <= '0;
    else if (hit) mode <= wdata;
  end
endmodule

// File: rtl/nvw_addr_gen.sv
module nvw_addr_gen #(
  parameter int ADDR_W = 8,
  parameter int PAGES  = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic                   rd_seq,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [$clog2(PAGES)-1:0] page,
  output logic                   win,
  output logic [$clog2(PAGES*PAGE_BYTES)-1:0] rom_idx
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [OFF_W-1:0] ptr;
  logic [OFF_W-1:0] off;

  assign win     = rd_seq || addr[ADDR_W-1];
  assign off     = rd_seq ? ptr : addr[OFF_W-1:0];
  assign rom_idx = {page, off};

  // Offset pointer wraps within the page by its width
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (rd_en && win) begin
      ptr <= off + 1'b1;
    end
  end
endmodule

// File: rtl/nvw_rom.sv
module nvw_rom #(
  parameter int DEPTH  = 1024,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] idx,
  output logic [DATA_W-1:0]        q
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = nvw_pkg::rom_init(i);
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[idx];
  end
endmodule

// File: rtl/nvw_rdata_pipe.sv
module nvw_rdata_pipe #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              win,
  input  logic [DATA_W-1:0] regval,
  input  logic [DATA_W-1:0] rom_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              s1_valid;
  logic              s1_win;
  logic [DATA_W-1:0] s1_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_win   <= 1'b0;
      s1_reg   <= '0;
      rvalid   <= 1'b0;
      rdata    <= '0;
    end else begin
      s1_valid <= rd_en;
      if (rd_en) begin
        s1_win <= win;
        s1_reg <= regval;
      end
      rvalid <= s1_valid;
      if (s1_valid) rdata <= s1_win ? rom_q : s1_reg;
    end
  end
endmodule

// File: rtl/nvm_page_window.sv
module nvm_page_window #(
  parameter int PAGES      = 8,
  parameter int PAGE_BYTES = 128,
  parameter logic [7:0] MODE_ADDR = 8'h0B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_seq,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_rvalid
);
  localparam int DATA_W = nvw_pkg::DATA_W;
  localparam int ADDR_W = nvw_pkg::ADDR_W;
  localparam int DEPTH  = PAGES * PAGE_BYTES;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int PAGE_W = $clog2(PAGES);

  logic [DATA_W-1:0] mode_q;
  logic              win;
  logic [IDX_W-1:0]  rom_idx;
  logic [DATA_W-1:0] rom_q;
  logic [DATA_W-1:0] regval;

  nvw_mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR)) u_mode (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .mode(mode_q)
  );

  nvw_addr_gen #(.ADDR_W(ADDR_W), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_agen (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .rd_seq(bus_seq), .addr(bus_addr),
    .page(mode_q[PAGE_W-1:0]), .win(win), .rom_idx(rom_idx)
  );

  nvw_rom #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rom (
    .clk(clk), .rd_en(bus_rd), .idx(rom_idx), .q(rom_q)
  );

  assign regval = (bus_addr == MODE_ADDR) ? mode_q : '0;

  nvw_rdata_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .win(win), .regval(regval),
    .rom_q(rom_q), .rdata(bus_rdata), .rvalid(bus_rvalid)
  );
endmodule

// File: rtl/nvw_checker.sv
module nvw_checker #(
  parameter logic [7:0] MODE_ADDR = 8'h0B
) (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] mode,
  input logic       rvalid,
  input logic [7:0] rdata
);
  assert_mode_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == MODE_ADDR) |=> (mode == $past(wdata)));

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == MODE_ADDR) |=> $stable(mode));

  assert_rvalid_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ##2 rvalid);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> ##2 !rvalid);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> $stable(rdata));
endmodule

bind nvm_page_window nvw_checker #(.MODE_ADDR(MODE_ADDR)) u_chk (
  .clk(clk), .rst(rst), .rd_en(bus_rd), .wr_en(bus_wr), .addr(bus_addr),
  .wdata(bus_wdata), .mode(mode_q), .rvalid(bus_rvalid), .rdata(bus_rdata)
);

// File: tb/nvm_page_window_bench.sv
module nvm_page_window_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] MODE_A = 8'h0B;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_seq = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] exp_mode = 8'h00;
  logic [6:0] exp_ptr = 7'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_page_window u_nvm_page_window (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_seq(bus_seq),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  function automatic logic [7:0] mem_byte(input int i);
    int v;
    v = i * 5 + (i / 128) * 59 + 17;
    return v[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == MODE_A) exp_mode = d;
  endtask

  // Issue a read, check that valid is still low one edge on, then check data
  task automatic do_read(input logic [7:0] a, input logic seq, input string req);
    logic [7:0] exp;
    logic [6:0] off;
    if (seq || a[7]) begin
      off = seq ? exp_ptr : a[6:0];
      exp = mem_byte(int'(exp_mode[2:0]) * 128 + int'(off));
      exp_ptr = off + 7'd1;
    end else begin
      exp = (a == MODE_A) ? exp_mode : 8'h00;
    end
    @(negedge clk);
    bus_addr = a; bus_seq = seq; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; bus_seq = 1'b0;
    check("R9 valid low one edge after read", {31'd0, bus_rvalid}, 32'd0);
    @(negedge clk);
    check("R9 valid two edges after read", {31'd0, bus_rvalid}, 32'd1);
    check(req, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
    do_read(MODE_A, 1'b0, "R1 page register reset value");

    // R2 window reads on page 0 at both ends
    do_read(8'h80, 1'b0, "R2 page0 first byte");
    do_read(8'hFF, 1'b0, "R2 page0 last byte");
    do_read(8'hA5, 1'b0, "R2 page0 middle byte");

    // R3 / R7 page change, immediately followed by a read
    do_write(MODE_A, 8'h07);
    do_read(8'h80, 1'b0, "R7 read right after page change");
    do_read(8'hFF, 1'b0, "R3 page7 last byte");
    do_write(MODE_A, 8'h03);
    do_read(8'h90, 1'b0, "R3 page3 byte");

    // R6 sequential wrap inside the page
    do_read(8'hFE, 1'b0, "R6 start of burst");
    do_read(8'h00, 1'b1, "R6 sequential to last offset");
    do_read(8'h00, 1'b1, "R6 wrap to first offset same page");
    do_read(8'h42, 1'b1, "R6 sequential ignores address");

    // R4 / R5 full byte readback, bit3 does not change window reads
    do_write(MODE_A, 8'hFA);
    do_read(MODE_A, 1'b0, "R4 page register readback");
    do_read(8'h81, 1'b0, "R5 bit3 set has no effect on window");

    // R8 window writes ignored
    do_write(8'h81, 8'h00);
    do_read(8'h81, 1'b0, "R8 window byte unchanged after write");
    do_read(MODE_A, 1'b0, "R8 page register unchanged after window write");

    // R10 other low addresses
    do_write(8'h05, 8'h5A);
    do_read(8'h05, 1'b0, "R10 unmapped low address reads zero");
    do_read(MODE_A, 1'b0, "R10 page register unchanged after low write");

    // Random mix of operations
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 2) do_write(MODE_A, 8'($urandom));
      else if (op == 2) do_write(8'($urandom), 8'($urandom));
      else if (op < 6) do_read({1'b1, 7'($urandom)}, 1'b0, "R2 random window read");
      else if (op < 8) do_read(8'($urandom), 1'b1, "R6 random sequential read");
      else do_read(8'($urandom), 1'b0, "R10 random any-address read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule